// File: doc/BRIEF.md
# Selectable-Resolution PWM Channel

This block is one pulse-width-modulated output channel that follows a free-running counter shared by several channels. It takes the low byte of that counter, a strobe that marks the edges at which the counter advances, a two-bit resolution code, two enable bits and a buffered duty value. The duty value is nine bits: an extra high bit and a duty byte. The channel compares the low 8, 7 or 6 bits of the counter against an active duty register and drives a registered output level.

The comparison is nine bits wide. The counter slice is zero-extended and the active value keeps its extra bit. This lets the channel reach both a constant-high output (0% low time) and a constant-low output. A new duty value reaches the active register only at the edge where the selected counter slice rolls over to zero. A change made in the middle of a period therefore never cuts a pulse short. When either enable bit is clear, the output rests at a fixed high level, but the active register keeps reloading at each rollover.

Top module: `pwm_res_channel`

## Requirements
- R1: `res_sel` picks the slice width: 2'b00 gives 8 bits, 2'b01 gives 7 bits, 2'b10 gives 6 bits, and 2'b11 also gives 8 bits. The output period is 256, 128 or 64 counter advances.
- R2: While enabled, the output is low when {1'b0, slice} < {active[8], active[7:0] masked to the slice width}, and high when it is greater than or equal to that value.
- R3: The active register takes {duty_ext, duty_byte} (extra bit at position 8, byte at [7:0]) only on a clock edge where `cnt_adv` is high and the slice is all ones. At every other edge the active register holds its value.
- R4: With an active extra bit of 0 and the masked duty field equal to zero (for example 00h, 80h or C0h in 8-, 7- or 6-bit mode), the output stays high for the whole period.
- R5: With an active extra bit of 1 and a duty byte of FFh, the output stays low for the whole period in every mode.
- R6: PWM operation requires both `cmp_en` and `pwm_en` to be high. Otherwise the output is high one clock later.
- R7: The active register reloads at rollover even while the channel is disabled. Once the channel is enabled, it uses the value loaded during the disabled time.
- R8: Reset clears the active register and drives the output high.
- R9: The output is registered. It reflects the counter and active value one clock edge after they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_lo | input | 8 | Low byte of the shared counter |
| cnt_adv | input | 1 | High when the shared counter advances at this edge |
| res_sel | input | 2 | Resolution code (see R1) |
| cmp_en | input | 1 | Compare enable |
| pwm_en | input | 1 | PWM enable |
| duty_ext | input | 1 | Buffered extra duty bit |
| duty_byte | input | 8 | Buffered duty byte |
| pwm_out | output | 1 | Registered PWM level |

## Verification
An active register loaded at the wrong moment shows at the port within one period as a duty that switches part-way through. The value seen there is either the previous duty or the new one, not the expected one. A wrong mask or comparator width shows as a misplaced edge in the first period after the mode is set. It also breaks the constant-high and constant-low cases at once. The bench runs an independent per-clock model and compares against it on every cycle. It also counts high cycles per period, so a misplaced edge of a single clock is reported during the period in which it happens.

// File: rtl/pwm_res_pkg.sv
package pwm_res_pkg;
    localparam int DUTY_W = 8;

    typedef enum logic [1:0] {
        RES_FULL  = 2'b00,
        RES_MINUS1 = 2'b01,
        RES_MINUS2 = 2'b10,
        RES_ALT   = 2'b11
    } res_e;

    typedef struct packed {
        logic [DUTY_W:0] act;
        logic            pwm;
    } chan_state_t;
endpackage

// File: rtl/pwm_slice_sel.sv
module pwm_slice_sel #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] cnt,
    input  logic [1:0]    res_sel,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] slice,
    output logic          at_top
);
    localparam int WBW = $clog2(DW + 1);

    logic [WBW-1:0] wbits;

    always_comb begin
        case (res_sel)
            2'b01:   wbits = WBW'(DW - 1);
            2'b10:   wbits = WBW'(DW - 2);
            default: wbits = WBW'(DW);
        endcase
    end

    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign mask[i] = (WBW'(i) < wbits);
    end

    assign slice  = cnt & mask;
    assign at_top = (slice == mask);
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] slice,
    input  logic [DW-1:0] mask,
    input  logic [DW:0]   act,
    output logic          ge
);
    logic [DW:0] lhs;
    logic [DW:0] rhs;

    assign lhs = {1'b0, slice};
    assign rhs = {act[DW], act[DW-1:0] & mask};
    assign ge  = (lhs >= rhs);
endmodule

// File: rtl/pwm_res_channel.sv
module pwm_res_channel
    import pwm_res_pkg::*;
#(
    parameter int DW = DUTY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cnt_lo,
    input  logic          cnt_adv,
    input  logic [1:0]    res_sel,
    input  logic          cmp_en,
    input  logic          pwm_en,
    input  logic          duty_ext,
    input  logic [DW-1:0] duty_byte,
    output logic          pwm_out
);
    chan_state_t st_d, st_q;

    logic [DW-1:0] mask, slice;
    logic          at_top, ge, run, wrap;

    pwm_slice_sel #(.DW(DW)) u_sel (
        .cnt     (cnt_lo),
        .res_sel (res_sel),
        .mask    (mask),
        .slice   (slice),
        .at_top  (at_top)
    );

    pwm_cmp #(.DW(DW)) u_cmp (
        .slice (slice),
        .mask  (mask),
        .act   (st_q.act),
        .ge    (ge)
    );

    assign run  = cmp_en & pwm_en;
    assign wrap = cnt_adv & at_top;

    always_comb begin
        st_d = st_q;
        // Output follows the comparison while running, rests high otherwise.
        st_d.pwm = run ? ge : 1'b1;
        // Shadow-to-active transfer only as the slice rolls over.
        if (wrap) st_d.act = {duty_ext, duty_byte};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act <= '0;
            st_q.pwm <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_out = st_q.pwm;

    assert_hold_off_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(st_q.act));

    assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pwm_out);

    assert_const_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q.act == {1'b1, {DW{1'b1}}}) |=> !pwm_out);

    assert_const_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !st_q.act[DW] && ((st_q.act[DW-1:0] & mask) == '0)) |=> pwm_out);

    assert_reload_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (st_q.act == $past({duty_ext, duty_byte})));
endmodule

// File: tb/tb_pwm_res_channel.sv
module tb_pwm_res_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cnt_lo = '0;
    logic       cnt_adv = 1'b0;
    logic [1:0] res_sel = 2'b00;
    logic       cmp_en = 1'b0;
    logic       pwm_en = 1'b0;
    logic       duty_ext = 1'b0;
    logic [7:0] duty_byte = '0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    int m_act = 0;
    int m_out = 1;
    int cnt_r = 0;
    string tag = "R8";

    always #4 clk = ~clk;

    pwm_res_channel dut (
        .clk(clk), .rst_n(rst_n), .cnt_lo(cnt_lo), .cnt_adv(cnt_adv),
        .res_sel(res_sel), .cmp_en(cmp_en), .pwm_en(pwm_en),
        .duty_ext(duty_ext), .duty_byte(duty_byte), .pwm_out(pwm_out)
    );

    // Behavioural reference model, evaluated on each rising edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 0;
            m_out = 1;
        end else begin
            int k, top, s, ref_v;
            k = (res_sel == 2'd1) ? 7 : (res_sel == 2'd2) ? 6 : 8;
            top = (1 << k) - 1;
            s = cnt_lo % (1 << k);
            ref_v = (m_act / 256) * 256 + (m_act % (1 << k));
            m_out = (cmp_en && pwm_en) ? ((s >= ref_v) ? 1 : 0) : 1;
            if (cnt_adv && s == top) m_act = duty_ext * 256 + duty_byte;
        end
    end

    task automatic check(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: pwm_out=%0d expected %0d at t=%0t", t, act, exp, $time);
        end
    endtask

    // One clock per step: check at falling edge, then drive next inputs.
    task automatic run(input int n, input logic [1:0] rs, input logic ex, input logic [7:0] db,
                       input logic ce, input logic pe, input bit gaps, input string t);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag, int'(pwm_out), m_out);
            tag = t;
            if (cnt_adv) cnt_r = (cnt_r + 1) % 256;
            cnt_lo = 8'(cnt_r);
            cnt_adv = gaps ? (i % 3 != 0) : 1'b1;
            res_sel = rs; duty_ext = ex; duty_byte = db;
            cmp_en = ce; pwm_en = pe;
        end
    endtask

    // Count high cycles over one period of 'per' advances starting at a period boundary.
    task automatic measure(input int per, input int exp_hi, input string t);
        int hi = 0;
        while (cnt_r % per != per - 1) run(1, res_sel, duty_ext, duty_byte, cmp_en, pwm_en, 0, t);
        run(1, res_sel, duty_ext, duty_byte, cmp_en, pwm_en, 0, t);
        for (int i = 0; i < per; i++) begin
            run(1, res_sel, duty_ext, duty_byte, cmp_en, pwm_en, 0, t);
            @(posedge clk); #1;
            hi += int'(pwm_out);
        end
        checks++;
        if (hi != exp_hi) begin
            errors++;
            $display("FAIL %s: high count=%0d expected %0d", t, hi, exp_hi);
        end
    endtask

    initial begin
        #50000000;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset level", int'(pwm_out), 1);
        rst_n = 1'b1;
        run(4, 2'b00, 1'b0, 8'h00, 1'b1, 1'b1, 0, "R8 cleared active gives high");
        // 8-bit mode, 25% low
        run(600, 2'b00, 1'b0, 8'h40, 1'b1, 1'b1, 0, "R1 R2 R9 8-bit");
        measure(256, 192, "R1 R2 8-bit period high count");
        // mid-period change must wait for rollover
        run(100, 2'b00, 1'b0, 8'h40, 1'b1, 1'b1, 0, "R3 before change");
        run(500, 2'b00, 1'b0, 8'hA0, 1'b1, 1'b1, 0, "R3 deferred reload");
        // 7-bit modes
        run(300, 2'b01, 1'b0, 8'h80, 1'b1, 1'b1, 0, "R4 7-bit full high");
        run(300, 2'b01, 1'b0, 8'h25, 1'b1, 1'b1, 0, "R1 R2 7-bit");
        measure(128, 128 - 8'h25, "R1 R2 7-bit period high count");
        // 6-bit modes
        run(200, 2'b10, 1'b0, 8'hC0, 1'b1, 1'b1, 0, "R4 6-bit full high");
        run(400, 2'b10, 1'b0, 8'h11, 1'b1, 1'b1, 1, "R1 R3 6-bit with idle clocks");
        measure(64, 64 - 8'h11, "R1 R2 6-bit period high count");
        // code 11 behaves as 8-bit
        run(600, 2'b11, 1'b0, 8'h30, 1'b1, 1'b1, 0, "R1 code 11 as 8-bit");
        measure(256, 256 - 8'h30, "R1 code 11 period high count");
        // constant low in all modes
        run(600, 2'b00, 1'b1, 8'hFF, 1'b1, 1'b1, 0, "R5 8-bit constant low");
        run(300, 2'b01, 1'b1, 8'hFF, 1'b1, 1'b1, 0, "R5 7-bit constant low");
        run(200, 2'b10, 1'b1, 8'hFF, 1'b1, 1'b1, 0, "R5 6-bit constant low");
        // enables
        run(300, 2'b00, 1'b1, 8'hFF, 1'b0, 1'b1, 0, "R6 compare disabled");
        run(300, 2'b00, 1'b1, 8'hFF, 1'b1, 1'b0, 0, "R6 pwm disabled");
        run(600, 2'b00, 1'b0, 8'hC0, 1'b0, 1'b0, 0, "R6 R7 reload while disabled");
        run(600, 2'b00, 1'b0, 8'hC0, 1'b1, 1'b1, 0, "R7 enabled after disabled reload");
        measure(256, 64, "R7 period high count");
        run(2, 2'b00, 1'b0, 8'hC0, 1'b1, 1'b1, 0, "R9 tail");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule